// File: doc/BRIEF.md
# Ring-Selective Fourth-Power Carrier Phase Estimator for 16QAM

This block gives a block-wise estimate of the carrier phase for a 16QAM symbol stream. It uses only the symbols whose ideal angle is a diagonal (45 degrees plus a multiple of 90 degrees). For 16QAM those symbols are the innermost and outermost rings, so the block can pick them out by magnitude alone. The middle ring carries the off-diagonal points and is excluded.

Each selected symbol is raised to the fourth power. For a diagonal point this turns the modulation angle into a fixed half-turn and leaves four times the carrier phase. The two complex squarings that form the fourth power round their results to limit word growth. The block sums the terms over a window of valid symbols. When the window closes, an iterative vectoring rotator finds the angle of the sum. The block removes the half-turn, divides by four, and reports the result with the number of symbols that contributed.

The estimate covers a quarter turn, so a true phase outside it comes back shifted by a multiple of 90 degrees. If a window holds no usable symbol, the block repeats the previous estimate.

Top module: `qam16_quad_phase_est`

## Requirements
- R1: While reset is held and until the first window closes, `est_valid`, `est_phase` and `est_count` are all zero.
- R2: Let A = 2^AMP_SH (16 by default). A symbol contributes only if I²+Q² < 6·A² (1536) or I²+Q² > 14·A² (3584). All other symbols are left out of both the sum and the count.
- R3: A window closes after every WIN (64) accepted symbols, where a symbol is accepted when `in_valid` is high at a clock edge. Idle cycles do not count towards the window. Each window gives exactly one `est_valid` pulse, one cycle wide, and the pulses come in window order.
- R4: `est_count` with a pulse equals the number of contributing symbols in that window.
- R5: `est_phase` is a signed angle where 2^PW units (16384 by default) make a full turn. It equals (arg(Σ s⁴) − π)/4, with the angle wrapped into [−π, π) before the division, to within 4 units.
- R6: A carrier rotation outside ±45 degrees is reported shifted by a multiple of 90 degrees into the range [−45, 45). For example, +60 degrees is reported as −30 degrees and −70 degrees as +20 degrees.
- R7: For a window with no contributing symbol, the pulse carries `est_count` = 0 and `est_phase` keeps the value of the previous pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Qualifies `in_i`/`in_q` in this cycle |
| in_i | input | DW (8) | In-phase sample, signed; grid levels ±A, ±3A |
| in_q | input | DW (8) | Quadrature sample, signed |
| est_valid | output | 1 | One-cycle pulse per closed window |
| est_phase | output | PW (14) | Phase estimate, signed, 2^PW units per turn |
| est_count | output | clog2(WIN+1) (7) | Contributing symbols in the window |

## Verification
The hardest case to reach is the selection boundary. No integer point sits exactly on a threshold, so the stimulus places symbols one step either side of each threshold: 1513 vs 1568 at the lower threshold, and 3445 vs 3613 at the upper one. The reported count then shows which side each symbol fell on.

A window made only of middle-ring points drives the hold path. It is placed directly after a window with a non-zero estimate, so a wrongly cleared or updated value would be visible.

Rotations of 60 and −70 degrees push the true phase past the estimator's quarter-turn range, which exposes the wrap. A window sent with idle gaps between its symbols shows that only accepted symbols advance the window.

// File: rtl/qpe_pkg.sv
// Shared constants for the ring-selective phase estimator.
// Holds the arctangent table used by the vectoring rotator.
// Assumes the angle width is at most 16 bits and the iteration count at most 16.
package qpe_pkg;

    // atan(2^-k) in units of 2^16 per full turn, for k = 0..15
    function automatic int atan_turn16(input int k);
        case (k)
            0:       return 8192;
            1:       return 4836;
            2:       return 2555;
            3:       return 1297;
            4:       return 651;
            5:       return 326;
            6:       return 163;
            7:       return 81;
            8:       return 41;
            9:       return 20;
            10:      return 10;
            11:      return 5;
            12:      return 3;
            13:      return 1;
            14:      return 1;
            default: return 0;
        endcase
    endfunction

    // Same angle rescaled (rounded) to 2^pw units per turn
    function automatic int atan_turn(input int k, input int pw);
        if (pw >= 16)
            return atan_turn16(k);
        return (atan_turn16(k) + (1 << (15 - pw))) >> (16 - pw);
    endfunction

endpackage

// File: rtl/qpe_ring_sel.sv
// Magnitude classifier: flags a symbol for use when its squared
// magnitude lies below TH_LO or above TH_HI (inner or outer ring).
// Purely combinational; assumes both thresholds fit in 2*DW+1 bits.
module qpe_ring_sel #(
    parameter int DW    = 8,
    parameter int TH_LO = 1536,
    parameter int TH_HI = 3584
) (
    input  logic signed [DW-1:0] i_in,
    input  logic signed [DW-1:0] q_in,
    output logic                 use_sym
);
    localparam int MW = 2 * DW + 1;
    localparam logic signed [MW-1:0] LO_S = MW'(TH_LO);
    localparam logic signed [MW-1:0] HI_S = MW'(TH_HI);

    logic signed [MW-1:0] ie, qe, mag2;

    // squared magnitude and ring decision
    always_comb begin
        ie      = MW'(i_in);
        qe      = MW'(q_in);
        mag2    = ie * ie + qe * qe;
        use_sym = (mag2 < LO_S) || (mag2 > HI_S);
    end
endmodule

// File: rtl/qpe_csquare.sv
// One registered complex squaring stage with round-half-up scaling by
// 2^SH. Carries a valid and a tag bit alongside the data.
// Assumes SH >= 1 and OW = 2*IW+1-SH.
module qpe_csquare #(
    parameter int IW = 8,
    parameter int SH = 4,
    parameter int OW = 2 * IW + 1 - SH
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_v,
    input  logic                 in_tag,
    input  logic signed [IW-1:0] in_re,
    input  logic signed [IW-1:0] in_im,
    output logic                 out_v,
    output logic                 out_tag,
    output logic signed [OW-1:0] out_re,
    output logic signed [OW-1:0] out_im
);
    localparam int FW = 2 * IW + 1;
    localparam logic signed [FW-1:0] RND = FW'(1) <<< (SH - 1);

    logic signed [FW-1:0] re_e, im_e, sq_re, sq_im, rs_re, rs_im;

    // full-precision square, then rounded scale-down
    always_comb begin
        re_e  = FW'(in_re);
        im_e  = FW'(in_im);
        sq_re = re_e * re_e - im_e * im_e;
        sq_im = (re_e * im_e) <<< 1;
        rs_re = (sq_re + RND) >>> SH;
        rs_im = (sq_im + RND) >>> SH;
    end

    // pipeline register for the stage
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_v   <= 1'b0;
            out_tag <= 1'b0;
            out_re  <= '0;
            out_im  <= '0;
        end else begin
            out_v   <= in_v;
            out_tag <= in_tag;
            out_re  <= OW'(rs_re);
            out_im  <= OW'(rs_im);
        end
    end
endmodule

// File: rtl/qpe_window_acc.sv
// Window accumulator: sums the tagged fourth-power terms and counts the
// tagged symbols over WIN valid inputs, then presents the totals with a
// one-cycle done pulse and restarts from zero. Assumes WIN >= 2.
module qpe_window_acc #(
    parameter int WIN   = 64,
    parameter int IW    = 21,
    parameter int ACC_W = 28,
    parameter int CNT_W = 7
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_v,
    input  logic                    in_use,
    input  logic signed [IW-1:0]    in_re,
    input  logic signed [IW-1:0]    in_im,
    output logic                    done,
    output logic signed [ACC_W-1:0] sum_re,
    output logic signed [ACC_W-1:0] sum_im,
    output logic [CNT_W-1:0]        sum_cnt
);
    localparam int SW = $clog2(WIN);
    localparam logic [SW-1:0] LAST = SW'(WIN - 1);

    logic signed [ACC_W-1:0] acc_re, acc_im, add_re, add_im;
    logic [CNT_W-1:0]        hits;
    logic [SW-1:0]           pos;

    // contribution of this symbol (zero when not selected)
    always_comb begin
        add_re = in_use ? ACC_W'(in_re) : '0;
        add_im = in_use ? ACC_W'(in_im) : '0;
    end

    // running sums and window close
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_re  <= '0;
            acc_im  <= '0;
            hits    <= '0;
            pos     <= '0;
            done    <= 1'b0;
            sum_re  <= '0;
            sum_im  <= '0;
            sum_cnt <= '0;
        end else begin
            done <= 1'b0;
            if (in_v) begin
                if (pos == LAST) begin
                    done    <= 1'b1;
                    sum_re  <= acc_re + add_re;
                    sum_im  <= acc_im + add_im;
                    sum_cnt <= hits + CNT_W'(in_use);
                    acc_re  <= '0;
                    acc_im  <= '0;
                    hits    <= '0;
                    pos     <= '0;
                end else begin
                    acc_re <= acc_re + add_re;
                    acc_im <= acc_im + add_im;
                    hits   <= hits + CNT_W'(in_use);
                    pos    <= pos + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/qpe_vector_angle.sv
// Iterative vectoring rotator: finds the angle of (x_in, y_in) in 2^PW
// units per turn over ITER cycles, removes a half turn and divides by
// four. With a zero count it skips the search and holds the last estimate.
// Assumes 2 <= ITER <= 16, PW <= 16, and no start while busy.
module qpe_vector_angle
    import qpe_pkg::*;
#(
    parameter int AW    = 28,
    parameter int PW    = 14,
    parameter int ITER  = 12,
    parameter int CNT_W = 7
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic signed [AW-1:0] x_in,
    input  logic signed [AW-1:0] y_in,
    input  logic [CNT_W-1:0]     cnt_in,
    output logic                 busy,
    output logic                 done,
    output logic [PW-1:0]        est,
    output logic [CNT_W-1:0]     cnt_out
);
    localparam int CW = AW + 2;
    localparam int KW = $clog2(ITER);
    localparam logic [PW-1:0] HALF = PW'(1) << (PW - 1);
    localparam logic [KW-1:0] KLAST = KW'(ITER - 1);

    logic signed [CW-1:0] x, y, xn, yn, xs, ys;
    logic [PW-1:0]        z, zn, at;
    logic signed [PW-1:0] zc;
    logic [KW-1:0]        k;
    logic [CNT_W-1:0]     cnt_hold;

    // one micro-rotation toward the positive x axis
    always_comb begin
        xs = x >>> k;
        ys = y >>> k;
        at = PW'(atan_turn(int'(k), PW));
        if (!y[CW-1]) begin
            xn = x + ys;
            yn = y - xs;
            zn = z + at;
        end else begin
            xn = x - ys;
            yn = y + xs;
            zn = z - at;
        end
        zc = $signed(zn + HALF);
    end

    // start, iterate and finish control
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            x        <= '0;
            y        <= '0;
            z        <= '0;
            k        <= '0;
            busy     <= 1'b0;
            done     <= 1'b0;
            est      <= '0;
            cnt_out  <= '0;
            cnt_hold <= '0;
        end else begin
            done <= 1'b0;
            if (start) begin
                cnt_hold <= cnt_in;
                if (cnt_in == '0) begin
                    done    <= 1'b1;
                    cnt_out <= '0;
                end else begin
                    busy <= 1'b1;
                    k    <= '0;
                    if (x_in[AW-1]) begin
                        x <= -CW'(x_in);
                        y <= -CW'(y_in);
                        z <= HALF;
                    end else begin
                        x <= CW'(x_in);
                        y <= CW'(y_in);
                        z <= '0;
                    end
                end
            end else if (busy) begin
                x <= xn;
                y <= yn;
                z <= zn;
                if (k == KLAST) begin
                    busy    <= 1'b0;
                    done    <= 1'b1;
                    est     <= PW'(zc >>> 2);
                    cnt_out <= cnt_hold;
                end else begin
                    k <= k + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/qam16_quad_phase_est.sv
// Top of the ring-selective fourth-power phase estimator for 16QAM.
// Classifies by magnitude, squares twice, sums over WIN symbols and
// converts the sum to a quarter-turn phase estimate with a count.
// Assumes WIN > ITER + 2 so that a window never closes while the angle
// unit is busy.
module qam16_quad_phase_est #(
    parameter int DW     = 8,
    parameter int AMP_SH = 4,
    parameter int WIN    = 64,
    parameter int SH1    = 4,
    parameter int SH2    = 6,
    parameter int PW     = 14,
    parameter int ITER   = 12,
    localparam int CNT_W = $clog2(WIN + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [DW-1:0]     in_i,
    input  logic [DW-1:0]     in_q,
    output logic              est_valid,
    output logic [PW-1:0]     est_phase,
    output logic [CNT_W-1:0]  est_count
);
    localparam int A2    = 1 << (2 * AMP_SH);
    localparam int TH_LO = 6 * A2;
    localparam int TH_HI = 14 * A2;
    localparam int S1W   = 2 * DW + 1 - SH1;
    localparam int P4W   = 2 * S1W + 1 - SH2;
    localparam int ACC_W = P4W + $clog2(WIN) + 1;

    logic                    sel0;
    logic                    v1, t1, v2, t2;
    logic signed [S1W-1:0]   re1, im1;
    logic signed [P4W-1:0]   re2, im2;
    logic                    win_done;
    logic signed [ACC_W-1:0] tot_re, tot_im;
    logic [CNT_W-1:0]        tot_cnt;
    logic                    ang_busy;

    qpe_ring_sel #(.DW(DW), .TH_LO(TH_LO), .TH_HI(TH_HI)) u_sel (
        .i_in    ($signed(in_i)),
        .q_in    ($signed(in_q)),
        .use_sym (sel0)
    );

    qpe_csquare #(.IW(DW), .SH(SH1), .OW(S1W)) u_sq1 (
        .clk     (clk),
        .rst_n   (rst_n),
        .in_v    (in_valid),
        .in_tag  (sel0),
        .in_re   ($signed(in_i)),
        .in_im   ($signed(in_q)),
        .out_v   (v1),
        .out_tag (t1),
        .out_re  (re1),
        .out_im  (im1)
    );

    qpe_csquare #(.IW(S1W), .SH(SH2), .OW(P4W)) u_sq2 (
        .clk     (clk),
        .rst_n   (rst_n),
        .in_v    (v1),
        .in_tag  (t1),
        .in_re   (re1),
        .in_im   (im1),
        .out_v   (v2),
        .out_tag (t2),
        .out_re  (re2),
        .out_im  (im2)
    );

    qpe_window_acc #(.WIN(WIN), .IW(P4W), .ACC_W(ACC_W), .CNT_W(CNT_W)) u_acc (
        .clk     (clk),
        .rst_n   (rst_n),
        .in_v    (v2),
        .in_use  (t2),
        .in_re   (re2),
        .in_im   (im2),
        .done    (win_done),
        .sum_re  (tot_re),
        .sum_im  (tot_im),
        .sum_cnt (tot_cnt)
    );

    qpe_vector_angle #(.AW(ACC_W), .PW(PW), .ITER(ITER), .CNT_W(CNT_W)) u_ang (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (win_done),
        .x_in    (tot_re),
        .y_in    (tot_im),
        .cnt_in  (tot_cnt),
        .busy    (ang_busy),
        .done    (est_valid),
        .est     (est_phase),
        .cnt_out (est_count)
    );
endmodule

// File: rtl/qpe_checker.sv
// Property checker for the phase estimator, attached by bind.
// Watches the output handshake and the hand-off into the angle unit.
module qpe_checker #(
    parameter int PW    = 14,
    parameter int WIN   = 64,
    parameter int CNT_W = 7
) (
    input logic             clk,
    input logic             rst_n,
    input logic             est_valid,
    input logic [PW-1:0]    est_phase,
    input logic [CNT_W-1:0] est_count,
    input logic             win_done,
    input logic             ang_busy
);
    // R1: reset clears all outputs
    a_r1_reset_clear: assert property (@(posedge clk)
        !rst_n |=> (!est_valid && est_phase == '0 && est_count == '0));

    // R3: the estimate pulse lasts one cycle
    a_r3_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        est_valid |=> !est_valid);

    // R3: a window never closes while the previous angle search runs
    a_r3_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
        win_done |-> !ang_busy);

    // R4: count cannot exceed the window length
    a_r4_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        est_valid |-> (int'(est_count) <= WIN));

    // R7: an empty window leaves the estimate untouched
    a_r7_hold_empty: assert property (@(posedge clk) disable iff (!rst_n)
        (est_valid && est_count == '0) |-> $stable(est_phase));
endmodule

bind qam16_quad_phase_est qpe_checker #(.PW(PW), .WIN(WIN), .CNT_W(CNT_W)) u_qpe_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .est_valid (est_valid),
    .est_phase (est_phase),
    .est_count (est_count),
    .win_done  (win_done),
    .ang_busy  (ang_busy)
);

// File: tb/qam16_quad_phase_est_bench.sv
`timescale 1ns/1ps
// Scoreboard bench: the driver sends whole windows and queues the
// expected estimate; the monitor pops and compares on each pulse.
module qam16_quad_phase_est_bench;
    localparam int DW    = 8;
    localparam int AMP_SH = 4;
    localparam int WIN   = 64;
    localparam int PW    = 14;
    localparam int CNT_W = $clog2(WIN + 1);
    localparam int AMP   = 1 << AMP_SH;
    localparam int TLO   = 6 * AMP * AMP;
    localparam int THI   = 14 * AMP * AMP;
    localparam real PI   = 3.14159265358979;

    typedef struct {
        real   est;
        int    cnt;
        bit    hold;
        string est_tag;
        string cnt_tag;
    } exp_t;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             in_valid = 1'b0;
    logic [DW-1:0]    in_i = '0;
    logic [DW-1:0]    in_q = '0;
    logic             est_valid;
    logic [PW-1:0]    est_phase;
    logic [CNT_W-1:0] est_count;

    int checks = 0;
    int failures = 0;
    int pulses = 0;
    int windows = 0;
    int last_est = 0;
    bit prev_v = 1'b0;
    bit finished = 1'b0;
    logic [31:0] seed = 32'h1234_5678;
    exp_t sb_q[$];

    always #5 clk = ~clk;

    qam16_quad_phase_est #(.DW(DW), .AMP_SH(AMP_SH), .WIN(WIN), .PW(PW)) u_qam16_quad_phase_est (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_i      (in_i),
        .in_q      (in_q),
        .est_valid (est_valid),
        .est_phase (est_phase),
        .est_count (est_count)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int rnd(input real x);
        return (x >= 0.0) ? $rtoi(x + 0.5) : -$rtoi(-x + 0.5);
    endfunction

    function automatic int lvl(input logic [1:0] b);
        case (b)
            2'd0:    return -3 * AMP;
            2'd1:    return -AMP;
            2'd2:    return AMP;
            default: return 3 * AMP;
        endcase
    endfunction

    // kind 0: any 16QAM point, 1: middle ring only, 2: threshold neighbours
    task automatic send_window(input real phi_deg, input int kind, input int gap,
                               input string etag, input string ctag);
        real  sre = 0.0, sim = 0.0, ph, a;
        int   cnt = 0;
        exp_t e;
        ph = phi_deg * PI / 180.0;
        for (int n = 0; n < WIN; n++) begin
            int bi, bq, ri, rq, m2;
            real ar, ai, br, bim;
            seed = seed * 32'd1103515245 + 32'd12345;
            if (kind == 0) begin
                bi = lvl(seed[17:16]);
                bq = lvl(seed[19:18]);
            end else if (kind == 1) begin
                bi = seed[20] ? 3 * AMP : AMP;
                bq = seed[20] ? AMP : 3 * AMP;
                if (seed[21]) bi = -bi;
                if (seed[22]) bq = -bq;
            end else begin
                case (seed[17:16])
                    2'd0:    begin bi = 28; bq = 27; end
                    2'd1:    begin bi = 28; bq = 28; end
                    2'd2:    begin bi = 42; bq = 41; end
                    default: begin bi = 43; bq = 42; end
                endcase
                if (seed[21]) bi = -bi;
                if (seed[22]) bq = -bq;
            end
            ri = rnd(bi * $cos(ph) - bq * $sin(ph));
            rq = rnd(bi * $sin(ph) + bq * $cos(ph));
            m2 = ri * ri + rq * rq;
            if (m2 < TLO || m2 > THI) begin
                cnt++;
                ar  = real'(ri * ri - rq * rq);
                ai  = 2.0 * real'(ri * rq);
                br  = ar * ar - ai * ai;
                bim = 2.0 * ar * ai;
                sre += br;
                sim += bim;
            end
            @(negedge clk);
            in_valid = 1'b1;
            in_i = DW'(ri);
            in_q = DW'(rq);
            for (int g = 0; g < gap; g++) begin
                @(negedge clk);
                in_valid = 1'b0;
            end
        end
        a = $atan2(sim, sre) - PI;
        while (a < -PI) a += 2.0 * PI;
        while (a >= PI) a -= 2.0 * PI;
        e.est = a / (2.0 * PI) * real'(1 << PW) / 4.0;
        e.cnt = cnt;
        e.hold = (cnt == 0);
        e.est_tag = etag;
        e.cnt_tag = ctag;
        sb_q.push_back(e);
        windows++;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    // monitor: compare each pulse with the head of the scoreboard
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            if (est_valid) begin
                int act;
                exp_t e;
                act = int'($signed(est_phase));
                chk(!prev_v, "R3", "est_valid wider than one cycle", 1, 0);
                pulses++;
                if (sb_q.size() == 0) begin
                    chk(1'b0, "R3", "pulse with no window queued", pulses, windows);
                end else begin
                    e = sb_q.pop_front();
                    chk(int'(est_count) == e.cnt, e.cnt_tag, "contributing count",
                        int'(est_count), e.cnt);
                    if (e.hold)
                        chk(act == last_est, "R7", "held estimate", act, last_est);
                    else
                        chk((act - rnd(e.est) <= 4) && (rnd(e.est) - act <= 4),
                            e.est_tag, "phase estimate", act, rnd(e.est));
                end
                last_est = act;
            end
            prev_v = est_valid;
        end
    end

    // watchdog: a hung run counts as a failure
    initial begin
        repeat (50000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            failures++;
            $display("FAIL R3 watchdog expired actual=%0d expected=%0d", pulses, windows);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (5) @(negedge clk);
        // R1: state right after reset
        chk(est_valid == 1'b0, "R1", "est_valid after reset", int'(est_valid), 0);
        chk(est_phase == '0, "R1", "est_phase after reset", int'(est_phase), 0);
        chk(est_count == '0, "R1", "est_count after reset", int'(est_count), 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        send_window(0.0,   0, 0, "R5", "R4");
        send_window(20.0,  0, 0, "R5", "R4");
        send_window(-30.0, 0, 2, "R3", "R3"); // gapped input, R3
        send_window(15.0,  1, 0, "R7", "R7"); // middle ring only, R7
        send_window(40.0,  0, 0, "R5", "R4");
        send_window(0.0,   2, 0, "R2", "R2"); // threshold neighbours, R2
        send_window(60.0,  0, 0, "R6", "R4"); // wraps to -30, R6
        send_window(10.0,  1, 1, "R7", "R7");
        send_window(-70.0, 0, 0, "R6", "R4"); // wraps to +20, R6

        repeat (60) @(negedge clk);
        finished = 1'b1;
        chk(pulses == windows, "R3", "one pulse per window", pulses, windows);
        chk(sb_q.size() == 0, "R3", "outstanding windows", sb_q.size(), 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule